// File: doc/BRIEF.md
# Tagged-Word Configuration Register Port

This block is the slave side of a small configuration port. A host reaches a bank of 7-bit registers over one shared 8-bit bus, a write strobe and a read strobe. Address bytes and data bytes use the same bus, and the top bit of each byte tells them apart. A write takes two strobes: first an address byte, then a data byte. To read a register, the host writes only its address. This loads a readback word, and the host then drives that word onto the bus with the read strobe. The readback word carries the stored 7 bits and an error flag. The flag is set when the register's contents differ from the last data value the host wrote.

The port works only while chip select is low and the two mode-select inputs choose configuration mode. All strobes are sampled in the block's clock domain. A write-strobe rising edge is seen as a low sample followed by a high sample.

Top module: `cfgport`

## Requirements
- R1: A strobed byte with bit 7 = 1 is an address and one with bit 7 = 0 is data. Register k answers to address ADDR_BASE + k, for k from 0 to NUM_REGS-1. With the default parameters, register k is at 8'h88 + k.
- R2: A data byte that follows a valid address stores bits 6..0 of the byte into the addressed register. That data byte also clears the pending address, so a second data byte changes nothing.
- R3: A data byte that arrives with no pending address is ignored. No register changes, and the value used as the error reference stays the same.
- R4: An address byte outside the register window clears the pending address, sets no register, and leaves the readback word as it was.
- R5: A valid address byte loads the readback word. Bits 6..0 hold the addressed register's contents and bit 7 holds the error flag.
- R6: The error flag is 1 only when a data write has happened since reset and the addressed register differs from the most recently written data value. Otherwise it is 0.
- R7: While cs_n = 0, rd_n = 0 and mode = 2'b11, dout_oe is 1 and dout equals the readback word. In every other case dout_oe is 0 and dout is 0.
- R8: A strobe takes effect at the first clock edge where wr_n is sampled high after a low sample. At that edge cs_n must be 0 and mode must be 2'b11; otherwise the strobe is ignored.
- R9: A wr_n rising edge is ignored while rd_n is low. This includes the case where rd_n falls in the same cycle that wr_n rises.
- R10: After reset, register k holds (37*k + 5) mod 128, no address is pending, the readback word is 8'h00, and no write is on record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe; acts on its rising edge |
| mode | input | 2 | Mode select; 2'b11 selects configuration mode |
| din | input | 8 | Bus byte from the host: bit 7 is the tag, bits 6..0 are the payload |
| dout | output | 8 | Readback word: bit 7 is the error flag, bits 6..0 are the register contents |
| dout_oe | output | 1 | High while the readback word is driven onto the bus |

## Verification
A write-strobe rising edge and the fall of the read strobe can land in the same clock cycle. In that case the write must lose: no register, pending address or readback word may change. The bench provokes this by releasing wr_n at the same edge where it lowers rd_n, with an address byte or a data byte on the bus. It then judges the result in two ways. The value seen on dout during that read must be the previously loaded word. A later full readback of every register must match the bench's arithmetic model. A second overlap is also checked: a data write followed at once by an address byte. This confirms that the error comparison uses the value that was just written.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int VAL_W = 7;

  typedef logic [VAL_W-1:0] cfg_val_t;

  typedef struct packed {
    logic     err;
    cfg_val_t val;
  } rb_word_t;

  // Reset contents of register k.
  function automatic cfg_val_t reset_value(input int unsigned k);
    return cfg_val_t'((k * 37 + 5) % 128);
  endfunction
endpackage

// File: rtl/cfgport_strobe.sv
module cfgport_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic wr_rise
);
  logic prev_q, prev_d;

  always_comb prev_d = wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign wr_rise = wr_n & ~prev_q;
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int          NUM_REGS  = 8,
  parameter logic [7:0]  ADDR_BASE = 8'h88,
  localparam int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [7:0]       word,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);
  logic [7:0] offset;

  always_comb begin
    offset = word - ADDR_BASE;
    hit    = word[7] && ({1'b0, offset} < LIMIT);
    idx    = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
  import cfgport_pkg::*;
#(
  parameter int  NUM_REGS = 8,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  cfg_val_t                  wval,
  output logic [NUM_REGS*VAL_W-1:0] regs_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    cfg_val_t q, d;
    logic     en;

    always_comb begin
      en = we && (widx == IDX_W'(k));
      d  = en ? wval : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reset_value(k);
      else        q <= d;
    end

    assign regs_flat[k*VAL_W +: VAL_W] = q;
  end
endmodule

// File: rtl/cfgport.sv
module cfgport
  import cfgport_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [7:0] ADDR_BASE = 8'h88,
  parameter logic [1:0] CFG_MODE  = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] mode,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                      wr_rise;
  logic                      dec_hit;
  logic [IDX_W-1:0]          dec_idx;
  logic [NUM_REGS*VAL_W-1:0] regs_flat;
  cfg_val_t                  rd_val;
  logic                      port_on, take, we;

  logic             pend_v_q, pend_v_d;
  logic [IDX_W-1:0] pend_idx_q, pend_idx_d;
  logic             last_v_q, last_v_d;
  cfg_val_t         last_val_q, last_val_d;
  rb_word_t         rb_q, rb_d;

  cfgport_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .wr_rise (wr_rise)
  );

  cfgport_decode #(.NUM_REGS(NUM_REGS), .ADDR_BASE(ADDR_BASE)) u_decode (
    .word (din),
    .hit  (dec_hit),
    .idx  (dec_idx)
  );

  cfgport_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .widx      (pend_idx_q),
    .wval      (din[VAL_W-1:0]),
    .regs_flat (regs_flat)
  );

  // Contents of the register named by the byte on the bus.
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (dec_idx == IDX_W'(k)) rd_val = regs_flat[k*VAL_W +: VAL_W];
    end
  end

  assign port_on = !cs_n && (mode == CFG_MODE);
  assign take    = wr_rise && port_on && rd_n;

  // Next-state logic for the address and data phases.
  always_comb begin
    pend_v_d   = pend_v_q;
    pend_idx_d = pend_idx_q;
    last_v_d   = last_v_q;
    last_val_d = last_val_q;
    rb_d       = rb_q;
    we         = 1'b0;
    if (take) begin
      if (din[7]) begin
        pend_v_d = dec_hit;
        if (dec_hit) begin
          pend_idx_d = dec_idx;
          rb_d.val   = rd_val;
          rb_d.err   = last_v_q && (rd_val != last_val_q);
        end
      end else if (pend_v_q) begin
        we         = 1'b1;
        pend_v_d   = 1'b0;
        last_v_d   = 1'b1;
        last_val_d = din[VAL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      last_v_q   <= 1'b0;
      last_val_q <= '0;
      rb_q       <= '0;
    end else begin
      pend_v_q   <= pend_v_d;
      pend_idx_q <= pend_idx_d;
      last_v_q   <= last_v_d;
      last_val_q <= last_val_d;
      rb_q       <= rb_d;
    end
  end

  assign dout_oe = port_on && !rd_n;
  assign dout    = dout_oe ? {rb_q.err, rb_q.val} : 8'h00;
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int         NUM_REGS = 8,
  parameter logic [1:0] CFG_MODE = 2'b11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  rd_n,
  input logic [1:0]            mode,
  input logic [7:0]            din,
  input logic [7:0]            dout,
  input logic                  dout_oe,
  input logic                  wr_rise,
  input logic                  dec_hit,
  input logic                  pend_v,
  input logic                  last_v,
  input logic [NUM_REGS*7-1:0] regs_flat
);
  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n || mode != CFG_MODE) |-> (!dout_oe && dout == 8'h00));

  assert_hold_no_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || mode != CFG_MODE) |=> ($stable(regs_flat) && $stable(pend_v)));

  assert_hold_rd_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> ($stable(regs_flat) && $stable(pend_v) && $stable(last_v)));

  assert_orphan_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !din[7] && !pend_v) |=> ($stable(regs_flat) && $stable(last_v)));

  assert_bad_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_n && rd_n && mode == CFG_MODE && din[7] && !dec_hit)
      |=> (!pend_v && $stable(regs_flat)));

  assert_err_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && dout[7]) |-> last_v);
endmodule

bind cfgport cfgport_chk #(.NUM_REGS(NUM_REGS), .CFG_MODE(CFG_MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .mode      (mode),
  .din       (din),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .wr_rise   (wr_rise),
  .dec_hit   (dec_hit),
  .pend_v    (pend_v_q),
  .last_v    (last_v_q),
  .regs_flat (regs_flat)
);

// File: tb/cfgport_bench.sv
`timescale 1ns/100ps
module cfgport_bench;
  localparam int NREG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_oe;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [6:0] mreg [NREG];
  logic [6:0] mlast;
  logic       mlast_v, mpend_v;
  int         mpend_idx;
  logic [7:0] mrb;

  always #2.5 clk = ~clk;

  cfgport u_cfgport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode(mode), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of one strobe edge, from the requirement text.
  task automatic model_apply(input logic [7:0] b, input logic rd_at_edge);
    int idx;
    if (cs_n || mode != 2'b11 || !rd_at_edge) return;
    if (b[7]) begin
      idx = int'(b) - 8'h88;
      if (idx >= 0 && idx < NREG) begin
        mpend_v = 1'b1; mpend_idx = idx;
        mrb = {mlast_v && (mreg[idx] != mlast), mreg[idx]};
      end else mpend_v = 1'b0;
    end else if (mpend_v) begin
      mreg[mpend_idx] = b[6:0];
      mlast = b[6:0]; mlast_v = 1'b1; mpend_v = 1'b0;
    end
  endtask

  // Full write strobe; optionally lower rd_n at the very edge wr_n rises.
  task automatic strobe(input logic [7:0] b, input logic rd_fall_with_rise = 1'b0);
    @(negedge clk) din = b; wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1;
    if (rd_fall_with_rise) rd_n = 1'b0;
    model_apply(b, rd_n);
    @(negedge clk);
  endtask

  task automatic read_chk(input string tag);
    @(negedge clk) rd_n = 1'b0;
    #1;
    chk({tag, " oe"}, dout_oe, 1'b1);
    chk({tag, " word"}, dout, mrb);
    @(negedge clk) rd_n = 1'b1;
  endtask

  task automatic read_reg(input int k, input string tag);
    strobe(8'(8'h88 + k));
    read_chk(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) mreg[k] = 7'((37 * k + 5) % 128);
    mlast = '0; mlast_v = 1'b0; mpend_v = 1'b0; mpend_idx = 0; mrb = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset oe", dout_oe, 1'b0);
    chk("R7 idle dout", dout, 8'h00);
    cs_n = 1'b0;
    read_chk("R10 reset readback word zero");

    // R10 / R5: defaults, error flag clear before any write.
    for (int k = 0; k < NREG; k++) read_reg(k, "R10 R5 default");

    // R1 R2 R6: write sweep, readback of same and neighbour register.
    for (int k = 0; k < NREG; k++) begin
      for (int v = 0; v < 128; v += 9) begin
        strobe(8'(8'h88 + k));
        strobe(8'(v));
        read_reg(k, "R2 R6 same reg");
        read_reg((k + 1) % NREG, "R6 neighbour reg");
      end
    end

    // R2 / R3: extra data after completed write, then orphan data.
    strobe(8'h8B); strobe(8'h15); strobe(8'h66);
    read_reg(3, "R2 second data ignored");
    strobe(8'h2C);
    read_reg(5, "R3 orphan data ignored");

    // R4: every address outside the window.
    for (int b = 8'h80; b < 256; b++) begin
      if (b >= 8'h88 && b < 8'h88 + NREG) continue;
      strobe(8'(8'h88 + b % NREG));
      strobe(8'(b));
      strobe(8'h2A);
      read_chk("R4 bad address");
    end

    // R8: deselected and wrong mode.
    cs_n = 1'b1;
    strobe(8'h8E); strobe(8'h7F);
    @(negedge clk) rd_n = 1'b0; #1;
    chk("R7 cs high oe", dout_oe, 1'b0);
    chk("R7 cs high dout", dout, 8'h00);
    @(negedge clk) rd_n = 1'b1;
    cs_n = 1'b0;
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      strobe(8'h89); strobe(8'(m + 3));
      @(negedge clk) rd_n = 1'b0; #1;
      chk("R7 mode oe", dout_oe, 1'b0);
      @(negedge clk) rd_n = 1'b1;
    end
    mode = 2'b11;
    read_reg(6, "R8 ignored strobes");
    read_reg(1, "R8 ignored strobes");

    // R9: wr rising while rd low, and rd falling in the same cycle.
    read_reg(2, "R9 prep");
    @(negedge clk) rd_n = 1'b0;
    strobe(8'h8F);
    #1 chk("R9 word during held read", dout, mrb);
    @(negedge clk) rd_n = 1'b1;
    strobe(8'h8A);
    strobe(8'h33, 1'b1);
    #1 chk("R9 same-cycle word", dout, mrb);
    @(negedge clk) rd_n = 1'b1;
    strobe(8'h44, 1'b1);
    @(negedge clk) rd_n = 1'b1;
    read_chk("R9 pending untouched");

    // Data write immediately followed by address compare (R6).
    strobe(8'h8D); strobe(8'h09);
    read_reg(0, "R6 fresh reference");

    for (int k = 0; k < NREG; k++) read_reg(k, "R1 final map");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule